// File: doc/BRIEF.md
# Pulse-Frame Gap Synchronizer

This block locks onto an intermittent pulse stream whose frames have a fixed layout of twenty time slots. An unsynchronized input is brought into the system clock domain and sampled on every clock. A programmable slot interval, counted in system clocks, divides time into slots, and each slot is marked pulsed when any sample inside it was high. The slot marks shift into a short history register.

A frame boundary is a pulsed slot that follows at least four empty slots. Such a run cannot occur inside a frame. Twenty slots after each boundary, the slot marks of that frame are captured. At the next boundary the block does three things. It reports the captured word. It reports the number of system clocks between the two boundaries. It flags the frame good or bad, judged by its two fixed-pulse slots and by whether twenty slots were captured at all. The first boundary after reset, or after the period counter has run out, only arms the block.

Top module: `pfgap_sync`

## Requirements
- R1: A slot lasts `slot_len` clocks, with values below 2 treated as 2. The first slot starts on the first clock after reset, and the input reaches the slot logic after two synchronizer clocks. A slot is marked pulsed if the input was high on at least one sampled clock within it, even for a single clock.
- R2: A boundary is a pulsed slot whose four preceding slots were all empty. A run of three empty slots inside a frame does not split that frame.
- R3: The first boundary after reset, and the first boundary after an unlock, raises `locked` and produces no strobe.
- R4: On every later boundary, `period` is loaded with the number of system clocks between that boundary slot's last clock and the previous one's, and `period_valid` pulses for one cycle.
- R5: At a reported boundary, `frame_word` bit k holds the mark of slot k+1 of the frame that began at the previous boundary (bit 0 is slot 1, bit 15 is slot 16).
- R6: `frame_valid` pulses with `period_valid` only if all twenty slots of that frame were captured and bits 0 and 15 of the word are set. Otherwise `frame_bad` pulses in its place.
- R7: When the period counter reaches its ceiling of 2^PER_W-1 clocks, `locked` clears. A boundary that lands on that same cycle is treated as a first boundary: no strobe, and `locked` remains set.
- R8: During and right after reset, all outputs are zero.
- R9: `frame_valid` and `frame_bad` never pulse together. Every strobe is one cycle wide and appears on the clock after the boundary slot's last clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous pulse stream |
| slot_len | input | SLOT_W | Slot interval in system clocks |
| frame_word | output | FRAME_SLOTS | Slot marks of the completed frame, bit 0 = slot 1 |
| frame_valid | output | 1 | One-cycle strobe: frame passed its checks |
| frame_bad | output | 1 | One-cycle strobe: frame failed its checks |
| period | output | PER_W | Clocks between the last two boundaries |
| period_valid | output | 1 | One-cycle strobe: `period` updated |
| locked | output | 1 | A boundary has been seen and the period counter has not run out |

## Verification
The two functions that can coincide are boundary detection and the period counter reaching its ceiling. The bench places two boundaries exactly 2^PER_W clocks apart, 128 slots of 8 clocks with PER_W set to 10, so the ceiling and the boundary fall on the same clock. It expects no strobe from that boundary, `locked` still high afterwards, and normal reports from the following frame. A companion spacing one slot shorter must report a period of 1016 clocks, which pins the edge of the window from the other side.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  // One slot result handed from the sampler to the tracker.
  typedef struct packed {
    logic tick;   // last clock of a slot
    logic pulse;  // slot contained at least one high sample
  } slot_sample_t;
endpackage

// File: rtl/pfg_sampler.sv
module pfg_sampler #(
  parameter int SLOT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pulse_in,
  input  logic [SLOT_W-1:0]     slot_len,
  output pfg_pkg::slot_sample_t slot_o
);
  logic              sync1, sync2;
  logic [SLOT_W-1:0] cnt;
  logic [SLOT_W-1:0] last_idx;
  logic              seen;
  logic              tick;

  // Slot intervals below two clocks are stretched to two.
  assign last_idx = (slot_len < SLOT_W'(2)) ? SLOT_W'(1) : slot_len - SLOT_W'(1);
  assign tick     = (cnt >= last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      cnt   <= '0;
      seen  <= 1'b0;
    end else begin
      sync1 <= pulse_in;
      sync2 <= sync1;
      cnt   <= tick ? '0 : cnt + SLOT_W'(1);
      seen  <= tick ? 1'b0 : (seen | sync2);
    end
  end

  assign slot_o.tick  = tick;
  assign slot_o.pulse = seen | sync2;

  // R1: a slot ends at most once every two clocks
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    slot_o.tick |=> !slot_o.tick);
endmodule

// File: rtl/pfg_gap_track.sv
module pfg_gap_track #(
  parameter int FRAME_SLOTS = 20,
  parameter int GAP_SLOTS   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  pfg_pkg::slot_sample_t  slot_i,
  output logic                   boundary,
  output logic [FRAME_SLOTS-1:0] pending,
  output logic                   pend_full
);
  localparam int HIST_W = FRAME_SLOTS - 1;
  localparam int SIDX_W = $clog2(FRAME_SLOTS + 1);

  logic [HIST_W-1:0]      hist;
  logic [FRAME_SLOTS-1:0] nxt_hist;
  logic [FRAME_SLOTS-1:0] cap_word;
  logic [SIDX_W-1:0]      sidx;

  assign nxt_hist = {hist, slot_i.pulse};
  assign boundary = slot_i.tick && slot_i.pulse && (hist[GAP_SLOTS-1:0] == '0);

  // Newest slot sits at bit 0 of the history; the word wants slot 1 at bit 0.
  for (genvar k = 0; k < FRAME_SLOTS; k++) begin : g_rev
    assign cap_word[k] = nxt_hist[FRAME_SLOTS-1-k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '1;
      sidx      <= '0;
      pending   <= '0;
      pend_full <= 1'b0;
    end else if (slot_i.tick) begin
      hist <= nxt_hist[HIST_W-1:0];
      if (boundary) begin
        sidx      <= SIDX_W'(1);
        pend_full <= 1'b0;
      end else if (sidx < SIDX_W'(FRAME_SLOTS)) begin
        sidx <= sidx + SIDX_W'(1);
        if (sidx == SIDX_W'(FRAME_SLOTS - 1)) begin
          pending   <= cap_word;
          pend_full <= 1'b1;
        end
      end
    end
  end

  // R5: a captured frame exists only once a full frame of slots has passed
  a_r5_full_needs_count: assert property (@(posedge clk) disable iff (rst)
    pend_full |-> (sidx == SIDX_W'(FRAME_SLOTS)));
  // R2: a boundary restarts the slot index at the first slot
  a_r2_restart_index: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (sidx == SIDX_W'(1)));
endmodule

// File: rtl/pfg_period.sv
module pfg_period #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  output logic             locked,
  output logic             lock_ok,
  output logic [PER_W-1:0] meas
);
  localparam logic [PER_W-1:0] CEIL = {PER_W{1'b1}};

  logic [PER_W-1:0] pcnt;

  assign lock_ok = locked && (pcnt != CEIL);
  assign meas    = pcnt + PER_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt   <= '0;
      locked <= 1'b0;
    end else if (boundary) begin
      pcnt   <= '0;
      locked <= 1'b1;
    end else if (pcnt != CEIL) begin
      pcnt <= pcnt + PER_W'(1);
    end else begin
      locked <= 1'b0;
    end
  end

  // R7: lock is lost only after the counter sat at its ceiling
  a_r7_unlock_at_ceiling: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(pcnt) == CEIL));
  // R3: every boundary leaves the block locked
  a_r3_lock_after_boundary: assert property (@(posedge clk) disable iff (rst)
    boundary |=> locked);
endmodule

// File: rtl/pfgap_sync.sv
module pfgap_sync #(
  parameter int SLOT_W      = 8,
  parameter int FRAME_SLOTS = 20,
  parameter int GAP_SLOTS   = 4,
  parameter int MARK_A      = 0,
  parameter int MARK_B      = 15,
  parameter int PER_W       = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pulse_in,
  input  logic [SLOT_W-1:0]      slot_len,
  output logic [FRAME_SLOTS-1:0] frame_word,
  output logic                   frame_valid,
  output logic                   frame_bad,
  output logic [PER_W-1:0]       period,
  output logic                   period_valid,
  output logic                   locked
);
  pfg_pkg::slot_sample_t  slot_s;
  logic                   boundary;
  logic [FRAME_SLOTS-1:0] pending;
  logic                   pend_full;
  logic                   lock_ok;
  logic [PER_W-1:0]       meas;
  logic                   marks_ok;

  pfg_sampler #(.SLOT_W(SLOT_W)) u_sampler (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .slot_len(slot_len), .slot_o(slot_s)
  );

  pfg_gap_track #(.FRAME_SLOTS(FRAME_SLOTS), .GAP_SLOTS(GAP_SLOTS)) u_track (
    .clk(clk), .rst(rst), .slot_i(slot_s), .boundary(boundary),
    .pending(pending), .pend_full(pend_full)
  );

  pfg_period #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst(rst), .boundary(boundary),
    .locked(locked), .lock_ok(lock_ok), .meas(meas)
  );

  assign marks_ok = pend_full && pending[MARK_A] && pending[MARK_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_word   <= '0;
      frame_valid  <= 1'b0;
      frame_bad    <= 1'b0;
      period       <= '0;
      period_valid <= 1'b0;
    end else begin
      frame_valid  <= 1'b0;
      frame_bad    <= 1'b0;
      period_valid <= 1'b0;
      if (boundary && lock_ok) begin
        frame_word   <= pending;
        period       <= meas;
        period_valid <= 1'b1;
        frame_valid  <= marks_ok;
        frame_bad    <= !marks_ok;
      end
    end
  end

  // R9: the two verdicts exclude each other
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(frame_valid && frame_bad));
  // R9: every period report carries exactly one verdict
  a_r9_verdict: assert property (@(posedge clk) disable iff (rst)
    period_valid |-> (frame_valid ^ frame_bad));
  // R9: strobes are one cycle wide
  a_r9_single: assert property (@(posedge clk) disable iff (rst)
    period_valid |=> !period_valid);
  // R3: acquiring lock produces no report
  a_r3_first_silent: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> !period_valid);
endmodule

// File: tb/pfgap_sync_bench.sv
`timescale 1ns/1ps
module pfgap_sync_bench;
  localparam int L  = 8;
  localparam int PW = 10;
  localparam int FS = 20;

  localparam logic [FS-1:0] FA = 20'b1010_1001_0110_1101_0011;
  localparam logic [FS-1:0] FB = 20'b0110_1011_1000_1110_0101;
  localparam logic [FS-1:0] FC = 20'hFFFFF;
  localparam logic [FS-1:0] FD = 20'b1101_1011_0110_1101_0001;
  localparam logic [FS-1:0] FE = 20'hF7FFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pulse_in = 1'b0;
  logic [7:0]    slot_len = 8'(L);
  logic [FS-1:0] frame_word;
  logic          frame_valid, frame_bad, period_valid, locked;
  logic [PW-1:0] period;

  int n_chk = 0, n_err = 0;
  int nv, nb, np, wide, lw, lp;
  logic pfv, pfb, ppv;

  always #5 clk = ~clk;

  pfgap_sync #(.PER_W(PW)) u_pfgap_sync (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .slot_len(slot_len),
    .frame_word(frame_word), .frame_valid(frame_valid), .frame_bad(frame_bad),
    .period(period), .period_valid(period_valid), .locked(locked)
  );

  always @(negedge clk) begin
    if (rst) begin
      pfv = 1'b0; pfb = 1'b0; ppv = 1'b0;
    end else begin
      if (frame_valid) begin nv++; lw = int'(frame_word); end
      if (frame_bad) nb++;
      if (period_valid) begin np++; lp = int'(period); end
      if ((frame_valid && pfv) || (frame_bad && pfb) || (period_valid && ppv)) wide++;
      pfv = frame_valid; pfb = frame_bad; ppv = period_valid;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic clear_log();
    nv = 0; nb = 0; np = 0; wide = 0; lw = -1; lp = -1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // One slot: a single-clock pulse early in the slot when b is set.
  task automatic send_slot(logic b);
    for (int i = 0; i < L; i++) begin
      pulse_in = (i == 1) && b;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) send_slot(1'b0);
  endtask

  task automatic send_bits(logic [FS-1:0] w, int n);
    for (int k = 0; k < n; k++) send_slot(w[k]);
  endtask

  task automatic prime(logic [FS-1:0] w);
    do_reset();
    idle(6);
    send_bits(w, FS);
    idle(4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 frame_valid in reset", int'(frame_valid), 0);
    chk("R8 frame_bad in reset", int'(frame_bad), 0);
    chk("R8 period_valid in reset", int'(period_valid), 0);
    chk("R8 locked in reset", int'(locked), 0);
    chk("R8 frame_word in reset", int'(frame_word), 0);
    chk("R8 period in reset", int'(period), 0);
  endtask

  task automatic t_first_and_stream();
    clear_log();
    prime(FA);
    chk("R3 no period on first boundary", np, 0);
    chk("R3 no verdict on first boundary", nv + nb, 0);
    chk("R3 locked after first boundary", int'(locked), 1);
    clear_log();
    send_bits(FB, FS);
    idle(6);
    chk("R6 one valid frame A", nv, 1);
    chk("R5 R1 word A", lw, int'(FA));
    chk("R4 period A 24 slots", lp, 24 * L);
    chk("R6 no bad for A", nb, 0);
    clear_log();
    send_bits(FC, FS);
    idle(2);
    chk("R5 word B", lw, int'(FB));
    chk("R4 period B 26 slots", lp, 26 * L);
    chk("R9 single strobes", wide, 0);
    chk("R4 one period report", np, 1);
  endtask

  task automatic t_run3();
    prime(FA);
    send_bits(FD, FS);
    idle(4);
    clear_log();
    send_bits(FC, FS);
    idle(2);
    chk("R2 run of three not split: reports", np, 1);
    chk("R2 word D intact", lw, int'(FD));
    chk("R2 no bad verdict", nb, 0);
  endtask

  task automatic t_bad();
    prime(FA);
    send_bits(FE, FS);
    idle(4);
    clear_log();
    send_bits(FC, 10);
    idle(4);
    chk("R6 slot16 empty flagged bad", nb, 1);
    chk("R6 slot16 empty not valid", nv, 0);
    chk("R4 period still reported", lp, 24 * L);
    chk("R9 exclusive strobes", np, 1);
    clear_log();
    send_bits(FC, FS);
    idle(2);
    chk("R6 short frame flagged bad", nb, 1);
    chk("R6 short frame not valid", nv, 0);
    chk("R4 short frame period", lp, 14 * L);
  endtask

  task automatic t_coincide();
    prime(FA);
    send_bits(FC, FS);
    idle(107);
    clear_log();
    send_bits(FC, FS);
    chk("R4 period just below ceiling", lp, 127 * L);
    chk("R6 long frame valid", nv, 1);
    idle(108);
    clear_log();
    send_bits(FC, FS);
    chk("R7 boundary at ceiling silent", np + nv + nb, 0);
    chk("R7 locked kept at ceiling", int'(locked), 1);
    idle(4);
    clear_log();
    send_bits(FC, FS);
    chk("R7 report after relock", np, 1);
    chk("R4 period after relock", lp, 24 * L);
  endtask

  task automatic t_saturate();
    prime(FA);
    clear_log();
    idle(200);
    chk("R7 lock lost after silence", int'(locked), 0);
    chk("R7 no reports in silence", np, 0);
    send_bits(FC, FS);
    idle(4);
    chk("R3 first after unlock silent", np, 0);
    chk("R3 relocked", int'(locked), 1);
    send_bits(FC, FS);
    chk("R4 report after unlock", lp, 24 * L);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    clear_log();
    t_reset();
    t_first_and_stream();
    t_run3();
    t_bad();
    t_coincide();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule